// File: doc/BRIEF.md
# Bus-Programmed Logarithmic Gain Control Register

This block is the digital control section of a programmable gain/attenuator. A host writes a ten-bit setting through an 8-bit parallel bus in two transfers: one address holds the coarse and fine step codes, the other holds the direction (boost or cut) and a power-down flag. A transfer is accepted on the rising edge of an active-low write strobe, and only while the active-low chip select is low.

The stored setting is decoded into a signed gain in tenths of a decibel. Each coarse step is worth 1.5 dB and each fine step 0.1 dB. The direction flag turns the value into a cut of the same size. The power-down flag drives an output that switches off the analog stage. While that output is high, the registers keep their contents and still accept writes. All inputs are sampled by a system clock. A one-cycle write-done pulse marks each accepted transfer.

Top module: `log_gain_ctrl`

## Requirements
- R1: After reset, `gain` is 0, `pwr_down` is 0 and `wr_done` is 0.
- R2: A write to address 0 stores bus bits [3:0] as the fine code and bits [7:4] as the coarse code. From the clock edge that detects the strobe's rising edge, `gain` has magnitude coarse*15 + fine.
- R3: Data is captured only at the rising edge of `wr_n`. While the strobe is held low or held high, the outputs do not change, even when the bus changes. The bus value present at the rising edge is the one stored.
- R4: A strobe rising edge while `cs_n` is high changes neither the outputs nor the stored state, and raises no `wr_done`.
- R5: A write to address 1 stores bus bit 0 as the direction flag and bus bit 1 as the power-down flag. Bus bits [7:2] are ignored.
- R6: When the direction flag is 1, `gain` is the negative of the magnitude, down to -240 for codes 15/15. When it is 0, `gain` is positive, up to +240.
- R7: `pwr_down` follows the stored power-down flag. While it is 1, writes to address 0 still update `gain`.
- R8: `wr_done` is high for exactly one cycle after each accepted write. It is high in the same cycle in which the new setting first appears.
- R9: A write to one address leaves the fields held at the other address unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cs_n | input | 1 | Active-low chip select qualifying writes |
| wr_n | input | 1 | Write strobe; data captured at its rising edge |
| addr | input | 1 | Register select: 0 = step codes, 1 = mode flags |
| data | input | 8 | Parallel data bus |
| gain | output | 10 | Signed decoded gain in 0.1 dB units |
| pwr_down | output | 1 | Power-down request to the analog section |
| wr_done | output | 1 | One-cycle pulse after an accepted write |

## Verification
The hardest case to reach from the ports is a strobe held low for several cycles while the bus keeps changing. Only the final bus value may land, and no intermediate value may. The bench holds `wr_n` low over four clock cycles and drives a different data byte in each one. It checks that the outputs stay frozen throughout. After releasing the strobe, it checks that only the last byte was stored. A second hard case is a full strobe pulse with `cs_n` high. The bench drives a complete write cycle with the chip deselected, then confirms that the outputs are unchanged and that no write-done pulse appeared.

// File: rtl/lgc_pkg.sv
// Package: shared constants and helper for the logarithmic gain control block.
// Assumes: tenths-of-a-decibel arithmetic; step sizes are integral in that unit.
package lgc_pkg;

    // Register select values on the address line.
    typedef enum logic {
        SEL_STEPS = 1'b0,
        SEL_FLAGS = 1'b1
    } reg_sel_e;

    // Default step weights in 0.1 dB units.
    localparam int unsigned COARSE_STEP_DEF = 15;
    localparam int unsigned FINE_STEP_DEF   = 1;

    // Largest magnitude reachable for a code width and step weights.
    function automatic int unsigned max_mag(input int unsigned code_w,
                                            input int unsigned c_step,
                                            input int unsigned f_step);
        int unsigned top_code;
        top_code = (1 << code_w) - 1;
        return top_code * c_step + top_code * f_step;
    endfunction

endpackage

// File: rtl/lgc_strobe_edge.sv
// Module: lgc_strobe_edge
// Detects the rising edge of the write strobe, sampled on the system clock.
// Assumes: strobe is already synchronous to clk; its history resets high so that
// a strobe idling high after reset does not produce a spurious edge.
module lgc_strobe_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic strb_n,
    output logic rise
);

    logic strb_q;

    // Remember the strobe level seen at the previous clock edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            strb_q <= 1'b1;
        end else begin
            strb_q <= strb_n;
        end
    end

    // Rising edge: high now, low one clock ago.
    always_comb begin
        rise = strb_n & ~strb_q;
    end

endmodule

// File: rtl/lgc_regs.sv
// Module: lgc_regs
// Holds the two address-selected control registers: the step codes and the mode
// flags. Generates a one-cycle done pulse for each accepted write.
// Assumes: wr_en is a single-cycle qualified write request.
module lgc_regs #(
    parameter int unsigned BUS_W     = 8,
    parameter int unsigned CODE_W    = 4,
    parameter int unsigned ATTEN_BIT = 0,
    parameter int unsigned PDN_BIT   = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              sel,
    input  logic [BUS_W-1:0]  wdata,
    output logic [CODE_W-1:0] coarse,
    output logic [CODE_W-1:0] fine,
    output logic              atten,
    output logic              pdn,
    output logic              done
);
    import lgc_pkg::*;

    localparam int unsigned FINE_LO   = 0;
    localparam int unsigned COARSE_LO = CODE_W;

    logic wr_steps;
    logic wr_flags;

    // Decode which register the current request targets.
    always_comb begin
        wr_steps = wr_en && (reg_sel_e'(sel) == SEL_STEPS);
        wr_flags = wr_en && (reg_sel_e'(sel) == SEL_FLAGS);
    end

    // Step-code register: fine in the low nibble, coarse above it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fine   <= '0;
            coarse <= '0;
        end else if (wr_steps) begin
            fine   <= wdata[FINE_LO +: CODE_W];
            coarse <= wdata[COARSE_LO +: CODE_W];
        end
    end

    // Mode-flag register: direction and power-down; other bus bits unused.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            atten <= 1'b0;
            pdn   <= 1'b0;
        end else if (wr_flags) begin
            atten <= wdata[ATTEN_BIT];
            pdn   <= wdata[PDN_BIT];
        end
    end

    // Done pulse: high the cycle after any accepted write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done <= 1'b0;
        end else begin
            done <= wr_en;
        end
    end

endmodule

// File: rtl/lgc_decode.sv
// Module: lgc_decode
// Converts the stored codes into a signed gain in 0.1 dB units.
// Assumes: GAIN_W is wide enough for the signed maximum magnitude.
module lgc_decode #(
    parameter int unsigned CODE_W      = 4,
    parameter int unsigned GAIN_W      = 10,
    parameter int unsigned COARSE_STEP = 15,
    parameter int unsigned FINE_STEP   = 1
) (
    input  logic [CODE_W-1:0]        coarse,
    input  logic [CODE_W-1:0]        fine,
    input  logic                     atten,
    output logic signed [GAIN_W-1:0] gain
);

    logic [GAIN_W-1:0] mag;

    // Magnitude: weighted sum of the coarse and fine codes.
    always_comb begin
        mag = GAIN_W'(coarse) * GAIN_W'(COARSE_STEP)
            + GAIN_W'(fine)   * GAIN_W'(FINE_STEP);
    end

    // Sign: a cut is the two's complement of the magnitude.
    always_comb begin
        if (atten) begin
            gain = -$signed(mag);
        end else begin
            gain = $signed(mag);
        end
    end

endmodule

// File: rtl/log_gain_ctrl.sv
// Module: log_gain_ctrl
// Top of the bus-programmed logarithmic gain control register. Writes are taken
// at the strobe's rising edge when chip select is low; the stored codes are
// decoded to a signed gain and a power-down request.
// Assumes: all bus inputs are synchronous to clk and stable around the strobe edge.
module log_gain_ctrl #(
    parameter int unsigned BUS_W       = 8,
    parameter int unsigned CODE_W      = 4,
    parameter int unsigned GAIN_W      = 10,
    parameter int unsigned COARSE_STEP = lgc_pkg::COARSE_STEP_DEF,
    parameter int unsigned FINE_STEP   = lgc_pkg::FINE_STEP_DEF
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     cs_n,
    input  logic                     wr_n,
    input  logic                     addr,
    input  logic [BUS_W-1:0]         data,
    output logic signed [GAIN_W-1:0] gain,
    output logic                     pwr_down,
    output logic                     wr_done
);

    logic              strb_rise;
    logic              wr_ok;
    logic [CODE_W-1:0] coarse_c;
    logic [CODE_W-1:0] fine_c;
    logic              atten_c;

    lgc_strobe_edge u_edge (
        .clk    (clk),
        .rst_n  (rst_n),
        .strb_n (wr_n),
        .rise   (strb_rise)
    );

    // Qualify the strobe edge with chip select.
    always_comb begin
        wr_ok = strb_rise & ~cs_n;
    end

    lgc_regs #(
        .BUS_W  (BUS_W),
        .CODE_W (CODE_W)
    ) u_regs (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (wr_ok),
        .sel    (addr),
        .wdata  (data),
        .coarse (coarse_c),
        .fine   (fine_c),
        .atten  (atten_c),
        .pdn    (pwr_down),
        .done   (wr_done)
    );

    lgc_decode #(
        .CODE_W      (CODE_W),
        .GAIN_W      (GAIN_W),
        .COARSE_STEP (COARSE_STEP),
        .FINE_STEP   (FINE_STEP)
    ) u_dec (
        .coarse (coarse_c),
        .fine   (fine_c),
        .atten  (atten_c),
        .gain   (gain)
    );

endmodule

// File: rtl/lgc_checker.sv
// Module: lgc_checker
// Port-level temporal checks for log_gain_ctrl, attached with bind below.
// Assumes: strobe history starts high after reset, matching the block's reset.
module lgc_checker #(
    parameter int unsigned BUS_W       = 8,
    parameter int unsigned CODE_W      = 4,
    parameter int unsigned GAIN_W      = 10,
    parameter int unsigned COARSE_STEP = 15,
    parameter int unsigned FINE_STEP   = 1
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic                     cs_n,
    input logic                     wr_n,
    input logic                     addr,
    input logic [BUS_W-1:0]         data,
    input logic signed [GAIN_W-1:0] gain,
    input logic                     pwr_down,
    input logic                     wr_done
);
    localparam int MAXG = int'(lgc_pkg::max_mag(CODE_W, COARSE_STEP, FINE_STEP));

    logic wr_seen_q;
    logic edge_now;

    // Track the strobe history, independent of the design's own register.
    always_ff @(posedge clk) begin
        if (!rst_n) wr_seen_q <= 1'b1;
        else        wr_seen_q <= wr_n;
    end

    assign edge_now = wr_n & ~wr_seen_q;

    p_done_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
        wr_done |=> !wr_done);

    p_done_after_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (edge_now && !cs_n) |=> wr_done);

    p_deselect_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (edge_now && cs_n) |=> ($stable(gain) && $stable(pwr_down) && !wr_done));

    p_no_edge_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !edge_now |=> ($stable(gain) && $stable(pwr_down)));

    p_pdn_capture_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (edge_now && !cs_n && addr) |=> (pwr_down == $past(data[1])));

    p_cut_sign_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (edge_now && !cs_n && addr && data[0]) |=> (gain <= 0));

    p_boost_sign_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (edge_now && !cs_n && addr && !data[0]) |=> (gain >= 0));

    p_range_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(gain) <= MAXG) && (int'(gain) >= -MAXG));

endmodule

bind log_gain_ctrl lgc_checker #(
    .BUS_W       (BUS_W),
    .CODE_W      (CODE_W),
    .GAIN_W      (GAIN_W),
    .COARSE_STEP (COARSE_STEP),
    .FINE_STEP   (FINE_STEP)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .cs_n     (cs_n),
    .wr_n     (wr_n),
    .addr     (addr),
    .data     (data),
    .gain     (gain),
    .pwr_down (pwr_down),
    .wr_done  (wr_done)
);

// File: tb/sim_log_gain_ctrl.sv
module sim_log_gain_ctrl;

    typedef struct {
        int    gain;
        bit    pd;
        string tag;
    } exp_t;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              cs_n = 1'b1;
    logic              wr_n = 1'b1;
    logic              addr = 1'b0;
    logic [7:0]        data = 8'h00;
    logic signed [9:0] gain;
    logic              pwr_down;
    logic              wr_done;

    int   errors = 0;
    int   checks = 0;
    bit   done_q = 1'b0;
    exp_t sb[$];

    // Reference model state.
    int m_coarse = 0, m_fine = 0;
    bit m_atten = 0, m_pd = 0;

    always #2.5 clk = ~clk;

    log_gain_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .wr_n(wr_n), .addr(addr),
        .data(data), .gain(gain), .pwr_down(pwr_down), .wr_done(wr_done)
    );

    function automatic int model_gain();
        int m;
        m = m_coarse * 15 + m_fine;
        return m_atten ? -m : m;
    endfunction

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic check_state(input string req);
        check({req, " gain"}, int'(gain), model_gain());
        check({req, " pwr_down"}, int'(pwr_down), int'(m_pd));
    endtask

    // Driver: one full strobe cycle, updates the model, pushes the expectation.
    task automatic bus_write(input bit a, input logic [7:0] d, input bit sel_n,
                             input string tag);
        exp_t e;
        @(negedge clk);
        cs_n = sel_n; addr = a; data = d; wr_n = 1'b0;
        @(negedge clk);
        wr_n = 1'b1;
        if (!sel_n) begin
            if (!a) begin
                m_fine = int'(d[3:0]); m_coarse = int'(d[7:4]);
            end else begin
                m_atten = d[0]; m_pd = d[1];
            end
            e.gain = model_gain(); e.pd = m_pd; e.tag = tag;
            sb.push_back(e);
        end
        @(negedge clk);
        @(negedge clk);
        cs_n = 1'b1;
        check_state(tag);
    endtask

    // Monitor: compare each write-done against the scoreboard head.
    always @(negedge clk) begin
        if (rst_n) begin
            if (wr_done && done_q) begin
                checks++; errors++;
                $display("FAIL R8: wr_done high two cycles, actual=1 expected=0");
            end
            if (wr_done) begin
                if (sb.size() == 0) begin
                    checks++; errors++;
                    $display("FAIL R4/R8: unexpected wr_done, actual=1 expected=0");
                end else begin
                    exp_t e;
                    e = sb.pop_front();
                    check({e.tag, " R8 gain at done"}, int'(gain), e.gain);
                    check({e.tag, " R8 pd at done"}, int'(pwr_down), int'(e.pd));
                end
            end
            done_q = wr_done;
        end
    end

    initial begin
        #(200000 * 5);
        errors++; checks++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 gain", int'(gain), 0);
        check("R1 pwr_down", int'(pwr_down), 0);
        check("R1 wr_done", int'(wr_done), 0);

        bus_write(1'b0, 8'h35, 1'b0, "R2 codes 3/5");
        bus_write(1'b1, 8'h01, 1'b0, "R6 cut -50");
        bus_write(1'b1, 8'hFC, 1'b0, "R5 upper bits ignored");
        bus_write(1'b0, 8'hFF, 1'b0, "R6 max boost");
        bus_write(1'b1, 8'h01, 1'b0, "R6 max cut");
        bus_write(1'b1, 8'h02, 1'b0, "R7 power down");
        bus_write(1'b0, 8'h12, 1'b0, "R7 R9 write while down");
        bus_write(1'b0, 8'h99, 1'b1, "R4 deselected steps");
        bus_write(1'b1, 8'h01, 1'b1, "R4 deselected flags");

        // R3: strobe held low while the bus changes; only the last byte lands.
        @(negedge clk);
        cs_n = 1'b0; addr = 1'b0; wr_n = 1'b0;
        for (int i = 0; i < 4; i++) begin
            data = 8'h40 + 8'(i);
            @(negedge clk);
            check_state("R3 strobe held low");
            check("R3 no done while low", int'(wr_done), 0);
        end
        data = 8'hA7;
        wr_n = 1'b1;
        m_coarse = 10; m_fine = 7;
        begin
            exp_t e;
            e.gain = model_gain(); e.pd = m_pd; e.tag = "R3 last byte";
            sb.push_back(e);
        end
        @(negedge clk);
        @(negedge clk);
        cs_n = 1'b1;
        check("R3 captured 157", int'(gain), 157);
        repeat (3) @(negedge clk);
        check_state("R3 strobe held high");

        bus_write(1'b1, 8'h00, 1'b0, "R7 power up");
        bus_write(1'b0, 8'h0F, 1'b0, "R2 fine only");
        check("R9 pd kept", int'(pwr_down), 0);

        repeat (2) @(negedge clk);
        check("R8 scoreboard drained", sb.size(), 0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule